// File: doc/BRIEF.md
# Multi-Mode Operand Address Generator

This block resolves one operand specifier of a register/memory instruction into either an operand value or a byte address for a data memory access. The caller presents a mode code together with a base register number and its current value, an index register value, a 32-bit constant field and an operand size. The block returns one of two things: an operand value, for the literal and register modes, or an effective address, for every memory mode. For modes that step the base register, it also returns a base-register writeback.

Most modes finish one cycle after they are accepted. The two memory-indirect modes must first read a pointer word from memory. They issue that read on a request/response port and wait for the response before they finish. The register file and the data memory live outside the block. The operand size is given as log2 of a byte count (0 to 3, meaning 1, 2, 4 or 8 bytes). That byte count is the step for autoincrement and autodecrement, and it is the scale factor for the indexed mode.

Top module: `opnd_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `done_o`, `mem_req_o` and `wb_en_o` are low.
- R2: A request is accepted when `start_i` is high and `busy_o` is low. For every mode other than 6 and 7, `done_o` is high in exactly the next cycle, for one cycle only. `start_i` is ignored while `busy_o` is high.
- R3: Mode 0 (short literal) sign-extends bits [5:0] of `disp_i`, covering -32 to 31, to 32 bits. It returns that value with `kind_o`=0 (operand value) and makes no memory request.
- R4: Mode 1 (absolute) returns `disp_i` with `kind_o`=1 (address). Mode 2 (register) returns the base value with `kind_o`=0. Mode 3 (register indirect) returns the base value with `kind_o`=1.
- R5: Mode 4 (predecrement) returns address base minus the size in bytes. It writes that same decremented value back to the base register.
- R6: Mode 5 (postincrement) returns the unmodified base as the address. It writes base plus the size in bytes back to the base register.
- R7: Modes 6 and 7 (memory indirect) raise `mem_req_o` in the cycle after acceptance, with `mem_addr_o` equal to the base value. Both signals are held until `mem_rvalid_i` is seen high at a clock edge. `done_o` follows in the next cycle, with `result_o` set to the returned word and `kind_o`=1.
- R8: Mode 7 (memory indirect with postincrement) also writes base plus 4 (one pointer word) back to the base register.
- R9: Mode 8 (displacement) returns address base plus `disp_i`.
- R10: Mode 9 (scaled index) returns address base plus `disp_i` plus the index value shifted left by `size_i`.
- R11: `wb_en_o` is high only in modes 4, 5 and 7, and only in the `done_o` cycle. `wb_num_o` then equals the accepted base register number.
- R12: Mode codes 10 to 15 behave as register indirect: the address is the base value, with no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| mode_i | input | 4 | Addressing mode code |
| base_num_i | input | 5 | Base register number |
| base_val_i | input | 32 | Base register value |
| index_val_i | input | 32 | Index register value |
| disp_i | input | 32 | Literal / absolute address / displacement |
| size_i | input | 2 | log2 of operand size in bytes |
| busy_o | output | 1 | Request in progress; new starts ignored |
| mem_req_o | output | 1 | Pointer read request |
| mem_addr_o | output | 32 | Pointer read address |
| mem_rvalid_i | input | 1 | Pointer read data valid |
| mem_rdata_i | input | 32 | Pointer read data |
| done_o | output | 1 | Result valid, one cycle |
| kind_o | output | 1 | 0 operand value, 1 memory address |
| result_o | output | 32 | Operand value or effective address |
| wb_en_o | output | 1 | Base register writeback enable |
| wb_num_o | output | 5 | Writeback register number |
| wb_val_o | output | 32 | Writeback value |

## Verification
The hardest case to reach from the ports is a memory-indirect request whose response is delayed. During the wait, `mem_req_o` and `mem_addr_o` must stay steady, `done_o` must stay low, and a new start must be dropped. The bench drives random response delays of 0 to 5 cycles. It also runs a directed long-delay case in which `start_i` is pulsed during the wait and again in the `done_o` cycle, and then confirms that no second result appears.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int MODE_W = 4;
  typedef logic [MODE_W-1:0] mode_t;
  localparam mode_t M_LIT     = 4'd0;
  localparam mode_t M_ABS     = 4'd1;
  localparam mode_t M_REG     = 4'd2;
  localparam mode_t M_RIND    = 4'd3;
  localparam mode_t M_PREDEC  = 4'd4;
  localparam mode_t M_POSTINC = 4'd5;
  localparam mode_t M_MIND    = 4'd6;
  localparam mode_t M_MINDINC = 4'd7;
  localparam mode_t M_DISP    = 4'd8;
  localparam mode_t M_SCALED  = 4'd9;

  localparam logic KIND_VAL  = 1'b0;
  localparam logic KIND_ADDR = 1'b1;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DONE} st_e;
endpackage

// File: rtl/eag_calc.sv
module eag_calc
  import eag_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LIT_W     = 6,
  parameter int SZ_W      = 2,
  parameter int PTR_BYTES = 4
) (
  input  mode_t           mode_i,
  input  logic [AW-1:0]   base_i,
  input  logic [AW-1:0]   index_i,
  input  logic [AW-1:0]   disp_i,
  input  logic [SZ_W-1:0] size_i,
  output logic [AW-1:0]   res_o,
  output logic            kind_o,
  output logic            fetch_o,
  output logic            wb_o,
  output logic [AW-1:0]   wb_val_o
);
  localparam int EXT_W = AW - LIT_W;

  logic [AW-1:0] step, lit, scaled, dec;

  always_comb begin
    step   = AW'(1) << size_i;
    lit    = {{EXT_W{disp_i[LIT_W-1]}}, disp_i[LIT_W-1:0]};
    scaled = index_i << size_i;
    dec    = base_i - step;
  end

  always_comb begin
    res_o    = base_i;
    kind_o   = KIND_ADDR;
    fetch_o  = 1'b0;
    wb_o     = 1'b0;
    wb_val_o = base_i;
    unique case (mode_i)
      M_LIT:     begin res_o = lit; kind_o = KIND_VAL; end
      M_ABS:     res_o = disp_i;
      M_REG:     kind_o = KIND_VAL;
      M_PREDEC:  begin res_o = dec; wb_o = 1'b1; wb_val_o = dec; end
      M_POSTINC: begin wb_o = 1'b1; wb_val_o = base_i + step; end
      M_MIND:    fetch_o = 1'b1;
      M_MINDINC: begin
        fetch_o  = 1'b1;
        wb_o     = 1'b1;
        wb_val_o = base_i + AW'(PTR_BYTES);
      end
      M_DISP:    res_o = base_i + disp_i;
      M_SCALED:  res_o = base_i + disp_i + scaled;
      default:   ;  // register indirect and reserved codes
    endcase
  end
endmodule

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [RW-1:0] base_num_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] c_res_i,
  input  logic          c_kind_i,
  input  logic          c_fetch_i,
  input  logic          c_wb_i,
  input  logic [AW-1:0] c_wb_val_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic          kind_o,
  output logic [AW-1:0] result_o,
  output logic          wb_en_o,
  output logic [RW-1:0] wb_num_o,
  output logic [AW-1:0] wb_val_o
);
  st_e           st_q;
  logic [AW-1:0] res_q, addr_q, wbv_q;
  logic [RW-1:0] wbn_q;
  logic          kind_q, wb_q;
  logic          accept;

  assign accept = start_i && (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      res_q  <= '0;
      addr_q <= '0;
      wbv_q  <= '0;
      wbn_q  <= '0;
      kind_q <= 1'b0;
      wb_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          res_q  <= c_res_i;
          addr_q <= base_i;
          kind_q <= c_kind_i;
          wb_q   <= c_wb_i;
          wbv_q  <= c_wb_val_i;
          wbn_q  <= base_num_i;
          st_q   <= c_fetch_i ? ST_FETCH : ST_DONE;
        end
        ST_FETCH: if (mem_rvalid_i) begin
          res_q <= mem_rdata_i;
          st_q  <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign mem_req_o  = (st_q == ST_FETCH);
  assign mem_addr_o = addr_q;
  assign done_o     = (st_q == ST_DONE);
  assign kind_o     = kind_q;
  assign result_o   = res_q;
  assign wb_en_o    = done_o && wb_q;
  assign wb_num_o   = wbn_q;
  assign wb_val_o   = wbv_q;

  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r2_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));
  a_r7_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  a_r7_req_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(start_i));
  a_r7_data_forwarded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(mem_req_o)) |-> (result_o == $past(mem_rdata_i)));
  a_r11_wb_addr_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (kind_o == KIND_ADDR && !mem_req_o));
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import eag_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic [RW-1:0] base_num_i,
  input  logic [AW-1:0] base_val_i,
  input  logic [AW-1:0] index_val_i,
  input  logic [AW-1:0] disp_i,
  input  logic [1:0]    size_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic          kind_o,
  output logic [AW-1:0] result_o,
  output logic          wb_en_o,
  output logic [RW-1:0] wb_num_o,
  output logic [AW-1:0] wb_val_o
);
  logic [AW-1:0] c_res, c_wb_val;
  logic          c_kind, c_fetch, c_wb;

  eag_calc #(.AW(AW)) u_calc (
    .mode_i  (mode_i),
    .base_i  (base_val_i),
    .index_i (index_val_i),
    .disp_i  (disp_i),
    .size_i  (size_i),
    .res_o   (c_res),
    .kind_o  (c_kind),
    .fetch_o (c_fetch),
    .wb_o    (c_wb),
    .wb_val_o(c_wb_val)
  );

  eag_ctrl #(.AW(AW), .RW(RW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .base_num_i  (base_num_i),
    .base_i      (base_val_i),
    .c_res_i     (c_res),
    .c_kind_i    (c_kind),
    .c_fetch_i   (c_fetch),
    .c_wb_i      (c_wb),
    .c_wb_val_i  (c_wb_val),
    .busy_o      (busy_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i (mem_rdata_i),
    .done_o      (done_o),
    .kind_o      (kind_o),
    .result_o    (result_o),
    .wb_en_o     (wb_en_o),
    .wb_num_o    (wb_num_o),
    .wb_val_o    (wb_val_o)
  );
endmodule

// File: tb/tb_opnd_addr_gen.sv
module tb_opnd_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [4:0]  bnum = '0;
  logic [31:0] bval = '0, ival = '0, disp = '0, rdata = '0;
  logic [1:0]  size = '0;
  logic        rvalid = 1'b0;
  logic        busy, mreq, done, kind, wben;
  logic [31:0] maddr, res, wbval;
  logic [4:0]  wbnum;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  opnd_addr_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .base_num_i(bnum), .base_val_i(bval), .index_val_i(ival), .disp_i(disp),
    .size_i(size), .busy_o(busy), .mem_req_o(mreq), .mem_addr_o(maddr),
    .mem_rvalid_i(rvalid), .mem_rdata_i(rdata), .done_o(done), .kind_o(kind),
    .result_o(res), .wb_en_o(wben), .wb_num_o(wbnum), .wb_val_o(wbval)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag(logic [3:0] m);
    case (m)
      4'd0: return "R3";
      4'd1, 4'd2, 4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      4'd9: return "R10";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [31:0] exp_res(logic [3:0] m, logic [31:0] b,
      logic [31:0] x, logic [31:0] d, logic [1:0] s, logic [31:0] ptr);
    int unsigned nb = 1 << s;
    case (m)
      4'd0: return 32'($signed(d[5:0]));
      4'd1: return d;
      4'd4: return b - nb;
      4'd6, 4'd7: return ptr;
      4'd8: return b + d;
      4'd9: return b + d + x * nb;
      default: return b;
    endcase
  endfunction

  function automatic logic exp_kind(logic [3:0] m);
    return !(m == 4'd0 || m == 4'd2);
  endfunction

  function automatic logic exp_wb(logic [3:0] m);
    return m == 4'd4 || m == 4'd5 || m == 4'd7;
  endfunction

  function automatic logic [31:0] exp_wbv(logic [3:0] m, logic [31:0] b, logic [1:0] s);
    case (m)
      4'd4: return b - (1 << s);
      4'd5: return b + (1 << s);
      default: return b + 4;
    endcase
  endfunction

  task automatic run_op(logic [3:0] m, logic [4:0] n, logic [31:0] b,
      logic [31:0] x, logic [31:0] d, logic [1:0] s, int dly, logic [31:0] ptr,
      bit poke);
    string t = tag(m);
    mode = m; bnum = n; bval = b; ival = x; disp = d; size = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (m == 4'd6 || m == 4'd7) begin
      for (int i = 0; i < dly; i++) begin
        chk("R7 req", {31'd0, mreq}, 32'd1);
        chk("R7 addr", maddr, b);
        chk("R7 no done", {31'd0, done}, 32'd0);
        if (poke) begin start = 1'b1; mode = 4'd0; end
        @(negedge clk);
        start = 1'b0;
      end
      chk("R7 req", {31'd0, mreq}, 32'd1);
      chk("R7 addr", maddr, b);
      rvalid = 1'b1; rdata = ptr;
      @(negedge clk);
      rvalid = 1'b0; rdata = $urandom;
    end else begin
      chk({t, " no req"}, {31'd0, mreq}, 32'd0);
    end
    chk("R2 done", {31'd0, done}, 32'd1);
    chk(t, res, exp_res(m, b, x, d, s, ptr));
    chk({t, " kind"}, {31'd0, kind}, {31'd0, exp_kind(m)});
    chk("R11 wb_en", {31'd0, wben}, {31'd0, exp_wb(m)});
    if (exp_wb(m)) begin
      chk("R11 wb_num", {27'd0, wbnum}, {27'd0, n});
      chk({t, " wb_val"}, wbval, exp_wbv(m, b, s));
    end
    if (poke) begin start = 1'b1; mode = 4'd2; end  // ignored while busy
    @(negedge clk);
    start = 1'b0;
    chk("R2 single done", {31'd0, done}, 32'd0);
    chk("R11 wb off", {31'd0, wben}, 32'd0);
    chk("R2 idle", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 req", {31'd0, mreq}, 32'd0);
    chk("R1 wb", {31'd0, wben}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle", {31'd0, busy}, 32'd0);

    // directed corners
    run_op(4'd0, 5'd1, 32'h0, 32'h0, 32'hFFFF_FFE0, 2'd0, 0, 32'h0, 0);  // -32
    run_op(4'd0, 5'd1, 32'h0, 32'h0, 32'h0000_005F, 2'd0, 0, 32'h0, 0);  // 31
    run_op(4'd4, 5'd7, 32'h0000_0004, 32'h0, 32'h0, 2'd3, 0, 32'h0, 0);  // wraps
    run_op(4'd5, 5'd9, 32'hFFFF_FFFF, 32'h0, 32'h0, 2'd0, 0, 32'h0, 0);
    run_op(4'd9, 5'd2, 32'h1000, 32'h3, 32'h10, 2'd3, 0, 32'h0, 0);
    run_op(4'd7, 5'd30, 32'h2000, 32'h0, 32'h0, 2'd1, 6, 32'hCAFE_F00D, 1);
    run_op(4'd6, 5'd3, 32'h3000, 32'h0, 32'h0, 2'd2, 0, 32'h1234_5678, 1);
    run_op(4'd15, 5'd4, 32'h4444, 32'h0, 32'h0, 2'd2, 0, 32'h0, 1);

    for (int k = 0; k < 400; k++) begin
      run_op(4'($urandom), 5'($urandom), $urandom, $urandom, $urandom,
             2'($urandom), $urandom_range(0, 5), $urandom, 1'($urandom));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule